// File: doc/BRIEF.md
# Flash Block Lock Protection Unit

This unit guards a word-addressed flash array of 512K words. The array is split into sixteen erase blocks of 32K words each. The unit keeps one lock bit per block and one permanent lock bit. For every erase, word write or lock configuration request it decides whether the request may go ahead. Two hardware unlock conditions can open a locked block: the write-protect input held high, or the reset pin sitting at its high-voltage level. Once the permanent lock bit is set, neither condition opens a locked block, and the per-block lock bits can no longer be changed.

A request is presented for one clock with `op_valid`. The verdict appears one cycle later as a single-cycle pulse on either `permit` or `lock_err`. Any lock-bit update takes effect on the same clock edge. The current lock state can also be read combinationally through an identifier-space address decode on `id_data`. The lock bits are volatile and are cleared only by reset, which stands for a fresh power-on.

Top module: `flk_lock_unit`

## Requirements
- R1: The block addressed by a request is word address bits [18:15]. Bits [14:0] are the offset within the block.
- R2: Operation codes 0 (erase) and 1 (word write) are permitted when the addressed block's lock bit is clear. They are also permitted when that bit is set, the permanent lock bit is clear, and either `wp_hi` or `rp_hv` is high.
- R3: When the permanent lock bit is set, an erase or word write to a block whose lock bit is set is refused for every level of `wp_hi` and `rp_hv`.
- R4: Operation code 3 sets the permanent lock bit only when `rp_hv` is high, and is refused otherwise. No operation ever clears the permanent lock bit.
- R5: Operation code 2 sets the addressed block's lock bit only when the permanent lock bit is clear and either `wp_hi` or `rp_hv` is high. Otherwise it is refused.
- R6: Operation code 4 clears all sixteen block lock bits in one step. It is refused when the permanent lock bit is set, and it also needs `wp_hi` or `rp_hv` high.
- R7: `id_data` returns the addressed block's lock bit on bit 0 when the block offset is 2. At word address 3 it returns the permanent lock bit on bit 0. All other bits of these words, and every unlisted address, read as zero.
- R8: `id_data` returns 16'h00B0 at word address 0 and 16'h0050 at word address 1.
- R9: A refused request raises `lock_err` for exactly one cycle and leaves all lock bits unchanged.
- R10: Reset clears all block lock bits and the permanent lock bit.
- R11: The verdict for a request accepted at a rising edge appears on `permit` or `lock_err` after that edge, never both, and lasts one cycle. Operation codes 5 to 7 raise neither output and change no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_code | input | 3 | Requested operation (0 erase, 1 word write, 2 lock block, 3 permanent lock, 4 unlock all) |
| addr | input | 19 | Word address of the request, also the identifier read address |
| wp_hi | input | 1 | Write-protect input at its high level |
| rp_hv | input | 1 | Reset pin at its high-voltage level |
| permit | output | 1 | Request allowed, one-cycle pulse |
| lock_err | output | 1 | Request refused, one-cycle pulse |
| id_data | output | 16 | Identifier-space readback for `addr` |

## Verification
The hardest state to reach is a locked block after the permanent lock bit has been set. The permanent bit cannot be undone, and once it is set no new block lock can be added. Random traffic would set it early and freeze the lock pattern. The stimulus therefore locks a chosen set of blocks first, with permanent-lock requests withheld, and then sets the permanent bit under a directed request. Random erase, write and unlock traffic with every combination of `wp_hi` and `rp_hv` then runs against the frozen pattern. A mid-run reset shows that the frozen state does clear at power-on.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [2:0] {
    OP_ERASE      = 3'd0,
    OP_WRITE      = 3'd1,
    OP_LOCK_BLK   = 3'd2,
    OP_LOCK_PERM  = 3'd3,
    OP_UNLOCK_ALL = 3'd4
  } op_e;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/flk_rst_sync.sv
module flk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/flk_addr_decode.sv
module flk_addr_decode #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_W  = 4,
  localparam int unsigned OFF_W = ADDR_W - BLK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk_idx,
  output logic [OFF_W-1:0]  blk_off
);
  assign blk_idx = addr[ADDR_W-1:OFF_W];
  assign blk_off = addr[OFF_W-1:0];
endmodule

// File: rtl/flk_policy.sv
module flk_policy
  import flk_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  input  logic            blk_locked,
  input  logic            perm_locked,
  input  logic            wp_hi,
  input  logic            rp_hv,
  output logic            legal,
  output logic            allow
);
  logic hw_unlock;
  op_e  op;

  always_comb begin
    op        = op_e'(op_code);
    hw_unlock = wp_hi | rp_hv;
    legal     = 1'b1;
    allow     = 1'b0;
    case (op)
      OP_ERASE, OP_WRITE: allow = !blk_locked || (!perm_locked && hw_unlock);
      OP_LOCK_BLK:        allow = !perm_locked && hw_unlock;
      OP_LOCK_PERM:       allow = rp_hv;
      OP_UNLOCK_ALL:      allow = !perm_locked && hw_unlock;
      default:            legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/flk_lock_regs.sv
module flk_lock_regs #(
  parameter int unsigned BLK_W = 4,
  localparam int unsigned NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_blk,
  input  logic [BLK_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic             set_perm,
  output logic [NBLK-1:0]  lock_bits,
  output logic             perm_bit
);
  logic [NBLK-1:0] lock_q;
  logic [NBLK-1:0] lock_d;
  logic [NBLK-1:0] lock_en;
  logic            perm_q;
  logic            perm_d;
  logic            perm_en;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_comb begin
      lock_en[g] = clr_all || (set_blk && (set_idx == BLK_W'(g)));
      lock_d[g]  = !clr_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lock_q[g] <= 1'b0;
      else if (lock_en[g]) lock_q[g] <= lock_d[g];
    end
  end

  always_comb begin
    perm_en = set_perm && !perm_q;
    perm_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       perm_q <= 1'b0;
    else if (perm_en) perm_q <= perm_d;
  end

  assign lock_bits = lock_q;
  assign perm_bit  = perm_q;
endmodule

// File: rtl/flk_id_read.sv
module flk_id_read #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLK_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00B0,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0050,
  localparam int unsigned OFF_W = ADDR_W - BLK_W,
  localparam int unsigned NBLK  = 1 << BLK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLK_W-1:0]  blk_idx,
  input  logic [OFF_W-1:0]  blk_off,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic              perm_bit,
  output logic [DATA_W-1:0] id_data
);
  localparam logic [OFF_W-1:0] LOCK_OFF = OFF_W'(2);

  always_comb begin
    id_data = '0;
    if (addr == ADDR_W'(0))          id_data = MFR_CODE;
    else if (addr == ADDR_W'(1))     id_data = DEV_CODE;
    else if (addr == ADDR_W'(3))     id_data = DATA_W'(perm_bit);
    else if (blk_off == LOCK_OFF)    id_data = DATA_W'(lock_bits[blk_idx]);
  end
endmodule

// File: rtl/flk_lock_unit.sv
module flk_lock_unit
  import flk_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned OFF_W = ADDR_W - BLK_W,
  localparam int unsigned NBLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_hi,
  input  logic              rp_hv,
  output logic              permit,
  output logic              lock_err,
  output logic [DATA_W-1:0] id_data
);
  logic             rst_sync_n;
  logic [BLK_W-1:0] blk_idx;
  logic [OFF_W-1:0] blk_off;
  logic [NBLK-1:0]  lock_q;
  logic             perm_q;
  logic             legal;
  logic             allow;
  logic             go;
  logic             set_blk;
  logic             clr_all;
  logic             set_perm;
  logic             permit_q, permit_d;
  logic             err_q, err_d;

  flk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  flk_addr_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
    .addr(addr), .blk_idx(blk_idx), .blk_off(blk_off)
  );

  flk_policy u_pol (
    .op_code(op_code), .blk_locked(lock_q[blk_idx]), .perm_locked(perm_q),
    .wp_hi(wp_hi), .rp_hv(rp_hv), .legal(legal), .allow(allow)
  );

  always_comb begin
    go       = op_valid && legal && allow;
    set_blk  = go && (op_e'(op_code) == OP_LOCK_BLK);
    clr_all  = go && (op_e'(op_code) == OP_UNLOCK_ALL);
    set_perm = go && (op_e'(op_code) == OP_LOCK_PERM);
    permit_d = go;
    err_d    = op_valid && legal && !allow;
  end

  flk_lock_regs #(.BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .set_blk(set_blk), .set_idx(blk_idx),
    .clr_all(clr_all), .set_perm(set_perm), .lock_bits(lock_q), .perm_bit(perm_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      permit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      permit_q <= permit_d;
      err_q    <= err_d;
    end
  end

  flk_id_read #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_id (
    .addr(addr), .blk_idx(blk_idx), .blk_off(blk_off),
    .lock_bits(lock_q), .perm_bit(perm_q), .id_data(id_data)
  );

  assign permit   = permit_q;
  assign lock_err = err_q;
endmodule

// File: rtl/flk_lock_unit_chk.sv
module flk_lock_unit_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_W  = 4,
  localparam int unsigned NBLK  = 1 << BLK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [ADDR_W-1:0] addr,
  input logic              wp_hi,
  input logic              rp_hv,
  input logic              permit,
  input logic              lock_err,
  input logic [NBLK-1:0]   lock_q,
  input logic              perm_q
);
  logic blk_hit;
  assign blk_hit = lock_q[addr[ADDR_W-1:ADDR_W-BLK_W]];

  assert_verdict_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && lock_err));

  assert_perm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  assert_perm_needs_hv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3 && !rp_hv) |=> !permit);

  assert_perm_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd1 && perm_q && blk_hit) |=> (lock_err && !permit));

  assert_refuse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> ($stable(lock_q) && $stable(perm_q)));

  assert_no_lock_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && perm_q) |=> $stable(lock_q));

  assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 3'd5) |=> (!permit && !lock_err));
endmodule

bind flk_lock_unit flk_lock_unit_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .addr(addr),
  .wp_hi(wp_hi), .rp_hv(rp_hv), .permit(permit), .lock_err(lock_err),
  .lock_q(lock_q), .perm_q(perm_q)
);

// File: tb/tb_flk_lock_unit.sv
module tb_flk_lock_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [18:0] addr;
  logic        wp_hi, rp_hv;
  logic        permit, lock_err;
  logic [15:0] id_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_lock;
  logic        m_perm;

  always #(CLK_PERIOD/2) clk = ~clk;

  flk_lock_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .addr(addr),
    .wp_hi(wp_hi), .rp_hv(rp_hv), .permit(permit), .lock_err(lock_err), .id_data(id_data)
  );

  function automatic bit exp_legal(input logic [2:0] c);
    return c <= 3'd4;
  endfunction

  function automatic bit exp_allow(input logic [2:0] c, input logic [18:0] a,
                                   input logic wp, input logic hv);
    logic bl;
    bl = m_lock[a[18:15]];
    case (c)
      3'd0, 3'd1: return !bl || (!m_perm && (wp || hv));
      3'd2:       return !m_perm && (wp || hv);
      3'd3:       return hv;
      3'd4:       return !m_perm && (wp || hv);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_id(input logic [18:0] a);
    if (a == 19'd0) return 16'h00B0;
    if (a == 19'd1) return 16'h0050;
    if (a == 19'd3) return {15'd0, m_perm};
    if (a[14:0] == 15'd2) return {15'd0, m_lock[a[18:15]]};
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] c, input logic [18:0] a, input logic wp,
                       input logic hv, input string req);
    bit al, lg;
    lg = exp_legal(c);
    al = lg && exp_allow(c, a, wp, hv);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; addr = a; wp_hi = wp; rp_hv = hv;
    @(negedge clk);
    op_valid = 1'b0;
    check(permit == al && lock_err == (lg && !al), req,
          {30'd0, permit, lock_err}, {30'd0, al, lg && !al});
    if (al) begin
      case (c)
        3'd2: m_lock[a[18:15]] = 1'b1;
        3'd3: m_perm = 1'b1;
        3'd4: m_lock = '0;
        default: ;
      endcase
    end
    @(negedge clk);
    check(!permit && !lock_err, "R11 single-cycle verdict", {30'd0, permit, lock_err}, 32'd0);
  endtask

  task automatic read_id(input logic [18:0] a, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(id_data == exp_id(a), req, {16'd0, id_data}, {16'd0, exp_id(a)});
  endtask

  task automatic check_all_locks(input string req);
    for (int b = 0; b < 16; b++) read_id({b[3:0], 15'd2}, req);
    read_id(19'd3, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lock = '0; m_perm = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [18:0] rnd_addr();
    logic [18:0] a;
    a = 19'($urandom);
    if ($urandom_range(0, 1) == 0) a[14:0] = 15'd2;
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op_valid = 0; op_code = 0; addr = 0; wp_hi = 0; rp_hv = 0;
    rst_n = 1'b0;
    m_lock = '0; m_perm = 1'b0;
    do_reset();

    // R10 reset state, R8 identifier codes
    check_all_locks("R10 reset clears locks");
    read_id(19'd0, "R8 manufacturer code");
    read_id(19'd1, "R8 device code");
    read_id(19'h12345, "R7 unlisted address reads zero");

    // R1/R5: lock block 5 via wp, block 9 via hv; refused without both
    do_op(3'd2, {4'd5, 15'h1234}, 1, 0, "R5 lock via wp");
    do_op(3'd2, {4'd9, 15'h0000}, 0, 1, "R5 lock via hv");
    do_op(3'd2, {4'd3, 15'h0007}, 0, 0, "R9 lock refused");
    check_all_locks("R1 lock landed in addressed block");

    // R2: erase and write to locked block
    do_op(3'd0, {4'd5, 15'h0100}, 0, 0, "R2 erase locked refused");
    do_op(3'd1, {4'd5, 15'h0100}, 1, 0, "R2 write locked via wp");
    do_op(3'd0, {4'd9, 15'h7FFF}, 0, 1, "R2 erase locked via hv");
    do_op(3'd1, {4'd4, 15'h7FFF}, 0, 0, "R2 write unlocked block");

    // R11 reserved codes
    do_op(3'd5, {4'd5, 15'd2}, 1, 1, "R11 reserved code quiet");
    do_op(3'd7, {4'd0, 15'd2}, 1, 1, "R11 reserved code quiet");
    check_all_locks("R11 reserved code leaves bits");

    // R6 unlock all
    do_op(3'd4, 19'd0, 0, 0, "R6 unlock refused no hw");
    check_all_locks("R9 state kept after refusal");
    do_op(3'd4, 19'd0, 1, 0, "R6 unlock all");
    check_all_locks("R6 all cleared");

    // R4 permanent requires hv
    do_op(3'd3, 19'd0, 1, 0, "R4 perm refused without hv");
    read_id(19'd3, "R4 perm still clear");

    // random phase without permanent lock
    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      if (c == 3'd3) c = 3'd2;
      do_op(c, rnd_addr(), 1'($urandom), 1'($urandom), "R2 random pre-perm");
      read_id(rnd_addr(), "R7 random readback");
    end

    // build a known pattern, then freeze it
    do_op(3'd4, 19'd0, 1, 1, "R6 unlock before freeze");
    do_op(3'd2, {4'd0, 15'd9}, 1, 0, "R5 lock block 0");
    do_op(3'd2, {4'd15, 15'd9}, 1, 0, "R5 lock block 15");
    do_op(3'd2, {4'd7, 15'd9}, 0, 1, "R5 lock block 7");
    do_op(3'd3, 19'h4ABCD, 0, 1, "R4 perm set with hv");
    read_id(19'd3, "R7 perm readback");
    do_op(3'd0, {4'd0, 15'd5}, 1, 1, "R3 erase locked after perm");
    do_op(3'd1, {4'd15, 15'd5}, 1, 0, "R3 write locked after perm");
    do_op(3'd1, {4'd6, 15'd5}, 0, 0, "R2 unlocked still writable");
    do_op(3'd2, {4'd6, 15'd5}, 1, 1, "R5 lock refused after perm");
    do_op(3'd4, 19'd0, 1, 1, "R6 unlock refused after perm");
    do_op(3'd3, 19'd0, 0, 0, "R4 perm op without hv");
    check_all_locks("R9 frozen pattern");

    for (int i = 0; i < 400; i++) begin
      do_op(3'($urandom_range(0, 7)), rnd_addr(), 1'($urandom), 1'($urandom),
            "R3 random post-perm");
      read_id(rnd_addr(), "R7 random readback post-perm");
    end
    check_all_locks("R4 perm never cleared");

    // R10 reset clears the frozen state
    do_reset();
    check_all_locks("R10 reset clears perm and locks");
    do_op(3'd2, {4'd6, 15'd5}, 1, 0, "R5 lock after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule